// File: doc/BRIEF.md
# Reset-Sequenced Clock Enable Controller

This block brings one peripheral out of the stopped state in a safe order. An enable request first checks whether the peripheral is already running. It counts as running only when its reset is released and its clock is on. If it is running, the request finishes at once and changes nothing. Otherwise the controller does the following in order:

1. It asserts the peripheral reset.
2. It waits a first interval.
3. It switches the clock on.
4. It waits a second, longer interval.
5. It releases the reset.

A disable request turns the clock off on the next edge and leaves the reset line alone.

Both waits are parameters counted in cycles of the controller's clock. The defaults give 100 us and 10 ms at a 25 MHz reference; a bench can scale them down. A build-time choice covers peripherals with no reset line: for these the clock is switched on directly, with no waits. Further build-time parameters set the following:

- the polarity of the clock-enable bit, since some stop bits disable when set;
- the values the clock and reset outputs take out of chip reset.

The controller accepts no request while a sequence is in progress. A one-cycle `done` pulse marks the end of every enable request.

Top module: `rstseq_clk_ctrl`

## Requirements
- R1: During and directly after synchronous reset, `busy` and `done` are 0. `per_rst` equals RST_INIT when a reset line exists and 0 otherwise. `gate_bit` equals CLK_INIT XOR CLK_ACTIVE_LOW.
- R2: An enable request sampled in idle while `per_rst` is 0 and the clock is logically on completes without side effects. `busy` is high for exactly one cycle, `done` rises on the second edge, and `per_rst` and `gate_bit` do not change.
- R3: A peripheral whose reset is asserted counts as not running even if its clock is on. An enable request then runs the full sequence, ending with `per_rst` low.
- R4: With a reset line, on a full sequence `per_rst` rises on the second clock edge after the edge that samples the request.
- R5: The clock turns logically on exactly WAIT1_CYC+1 edges after `per_rst` rises, while `per_rst` is still high.
- R6: `per_rst` falls exactly WAIT2_CYC+1 edges after the clock turns on. On that same edge `done` goes high for one cycle and `busy` goes low.
- R7: Without a reset line, `per_rst` stays 0. An enable request on a stopped clock turns the clock on at the second edge after the sampling edge. On that same edge `done` pulses and `busy` drops.
- R8: A disable request sampled in idle turns the clock logically off on that edge. `per_rst` is unchanged, `busy` stays low and no `done` is produced.
- R9: Enable or disable requests sampled while `busy` is high are ignored. The running sequence keeps its timing, the clock stays on, and no second sequence follows.
- R10: When enable and disable are sampled together in idle, the disable takes effect and no sequence starts.
- R11: `gate_bit` is the logical clock state XOR CLK_ACTIVE_LOW. With CLK_ACTIVE_LOW=1, a running peripheral shows `gate_bit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all waits count its cycles |
| rst | input | 1 | Synchronous active-high reset of the controller |
| en_req | input | 1 | Enable request, sampled when idle |
| dis_req | input | 1 | Disable request, sampled when idle |
| busy | output | 1 | High while a request is being processed |
| done | output | 1 | One-cycle pulse at the end of an enable request |
| gate_bit | output | 1 | Clock stop/enable bit in the configured polarity |
| per_rst | output | 1 | Active-high reset to the peripheral |

## Verification
A wrong state in this block shows up as a shift in the edges of `per_rst` and the clock relative to the request. Such a shift appears within one sequence, so the bench times every edge against values computed from the two wait parameters.

A wrong running check shows within two cycles. Either `done` arrives early on a peripheral held in reset, or a needless reset pulse hits a running one.

The bench injects stray requests at every offset inside a sequence. A controller that leaks a request past `busy` therefore shows either a clock drop or an extra busy period right after the sequence.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Sequencer states; order only matters for readability.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ASSERT_RST,
        ST_WAIT1,
        ST_CLK_ON,
        ST_WAIT2,
        ST_RELEASE
    } seq_state_e;

    // One-cycle commands from the sequencer to the output registers.
    typedef struct packed {
        logic rst_set;
        logic rst_clr;
        logic clk_set;
        logic clk_clr;
        logic done;
    } seq_cmd_t;

    // A peripheral runs only when out of reset with its clock on.
    function automatic logic periph_running(input logic rst_asserted, input logic clk_on);
        return !rst_asserted && clk_on;
    endfunction
endpackage

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
    parameter int WAIT1_CYC = 4,
    parameter int WAIT2_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load_first,
    input  logic load_second,
    output logic zero
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int MAXW = (WAIT1_CYC > WAIT2_CYC) ? WAIT1_CYC : WAIT2_CYC;
    localparam int CW   = $clog2(MAXW + 1);

    logic [CW-1:0] cnt_q;

    // Loaded with length-1; the wait state exits on the cycle it reads zero.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_first) begin
            cnt_q <= CW'(WAIT1_CYC - 1);
        end else if (load_second) begin
            cnt_q <= CW'(WAIT2_CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter bit HAS_RESET = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en_req,
    input  logic     dis_req,
    input  logic     running,
    input  logic     tmr_zero,
    output seq_cmd_t cmd,
    output logic     tmr_load1,
    output logic     tmr_load2,
    output logic     busy
);
    timeunit 1ns;
    timeprecision 1ps;

    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        cmd       = '0;
        tmr_load1 = 1'b0;
        tmr_load2 = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                // Disable wins over a simultaneous enable.
                if (dis_req)     cmd.clk_clr = 1'b1;
                else if (en_req) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (running) begin
                    cmd.done = 1'b1;
                    state_d  = ST_IDLE;
                end else if (HAS_RESET) begin
                    state_d = ST_ASSERT_RST;
                end else begin
                    state_d = ST_CLK_ON;
                end
            end
            ST_ASSERT_RST: begin
                cmd.rst_set = 1'b1;
                tmr_load1   = 1'b1;
                state_d     = ST_WAIT1;
            end
            ST_WAIT1: begin
                if (tmr_zero) state_d = ST_CLK_ON;
            end
            ST_CLK_ON: begin
                cmd.clk_set = 1'b1;
                if (HAS_RESET) begin
                    tmr_load2 = 1'b1;
                    state_d   = ST_WAIT2;
                end else begin
                    cmd.done = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            ST_WAIT2: begin
                if (tmr_zero) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                cmd.rst_clr = 1'b1;
                cmd.done    = 1'b1;
                state_d     = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/rstseq_outregs.sv
module rstseq_outregs
    import rstseq_pkg::*;
#(
    parameter bit HAS_RESET      = 1'b1,
    parameter bit CLK_ACTIVE_LOW = 1'b1,
    parameter bit CLK_INIT       = 1'b0,
    parameter bit RST_INIT       = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  seq_cmd_t cmd,
    output logic     clk_on,
    output logic     rst_on,
    output logic     gate_bit,
    output logic     done
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam bit RST_RESET_VAL = HAS_RESET ? RST_INIT : 1'b0;

    logic clk_on_q;
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst)              clk_on_q <= CLK_INIT;
        else if (cmd.clk_set) clk_on_q <= 1'b1;
        else if (cmd.clk_clr) clk_on_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= cmd.done;
    end

    generate
        if (HAS_RESET) begin : g_reset_line
            logic rst_q;
            always_ff @(posedge clk) begin
                if (rst)              rst_q <= RST_RESET_VAL;
                else if (cmd.rst_set) rst_q <= 1'b1;
                else if (cmd.rst_clr) rst_q <= 1'b0;
            end
            assign rst_on = rst_q;
        end else begin : g_no_reset_line
            logic unused_rst_cmds;
            assign unused_rst_cmds = cmd.rst_set | cmd.rst_clr;
            assign rst_on = 1'b0;
        end
    endgenerate

    assign clk_on   = clk_on_q;
    assign gate_bit = clk_on_q ^ CLK_ACTIVE_LOW;
    assign done     = done_q;
endmodule

// File: rtl/rstseq_clk_ctrl.sv
module rstseq_clk_ctrl
    import rstseq_pkg::*;
#(
    parameter int WAIT1_CYC      = 2500,
    parameter int WAIT2_CYC      = 250000,
    parameter bit HAS_RESET      = 1'b1,
    parameter bit CLK_ACTIVE_LOW = 1'b1,
    parameter bit CLK_INIT       = 1'b0,
    parameter bit RST_INIT       = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic en_req,
    input  logic dis_req,
    output logic busy,
    output logic done,
    output logic gate_bit,
    output logic per_rst
);
    timeunit 1ns;
    timeprecision 1ps;

    seq_cmd_t cmd;
    logic     tmr_load1, tmr_load2, tmr_zero;
    logic     clk_on, rst_on, running;

    assign running = periph_running(rst_on, clk_on);

    rstseq_fsm #(
        .HAS_RESET (HAS_RESET)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en_req    (en_req),
        .dis_req   (dis_req),
        .running   (running),
        .tmr_zero  (tmr_zero),
        .cmd       (cmd),
        .tmr_load1 (tmr_load1),
        .tmr_load2 (tmr_load2),
        .busy      (busy)
    );

    rstseq_timer #(
        .WAIT1_CYC (WAIT1_CYC),
        .WAIT2_CYC (WAIT2_CYC)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .load_first  (tmr_load1),
        .load_second (tmr_load2),
        .zero        (tmr_zero)
    );

    rstseq_outregs #(
        .HAS_RESET      (HAS_RESET),
        .CLK_ACTIVE_LOW (CLK_ACTIVE_LOW),
        .CLK_INIT       (CLK_INIT),
        .RST_INIT       (RST_INIT)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .clk_on   (clk_on),
        .rst_on   (rst_on),
        .gate_bit (gate_bit),
        .done     (done)
    );

    assign per_rst = rst_on;
endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker #(
    parameter bit HAS_RESET      = 1'b1,
    parameter bit CLK_ACTIVE_LOW = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic gate_bit,
    input logic per_rst
);
    timeunit 1ns;
    timeprecision 1ps;

    logic clk_l;
    assign clk_l = gate_bit ^ CLK_ACTIVE_LOW;

    // R5: the clock may only come on while the peripheral is held in reset
    a_r5_clock_rises_in_reset: assert property (@(posedge clk) disable iff (rst)
        (HAS_RESET && $rose(clk_l)) |-> per_rst);

    // R6: reset is released only with the clock running
    a_r6_release_with_clock: assert property (@(posedge clk) disable iff (rst)
        $fell(per_rst) |-> clk_l);

    // R6: done lasts one cycle
    a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: done appears exactly as busy drops
    a_r2_done_at_busy_fall: assert property (@(posedge clk) disable iff (rst)
        done |-> $fell(busy));

    // R8: a clock drop never touches the reset line and never starts a sequence
    a_r8_disable_leaves_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_l) |-> ($stable(per_rst) && !busy));

    // R9: no clock drop can result from a request seen while busy
    a_r9_no_drop_after_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> !$fell(clk_l));

    // R7: no reset line means the reset output stays low
    a_r7_no_reset_line: assert property (@(posedge clk) disable iff (rst)
        !HAS_RESET |-> !per_rst);
endmodule

bind rstseq_clk_ctrl rstseq_checker #(
    .HAS_RESET      (HAS_RESET),
    .CLK_ACTIVE_LOW (CLK_ACTIVE_LOW)
) u_rstseq_checker (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .gate_bit (gate_bit),
    .per_rst  (per_rst)
);

// File: tb/rstseq_clk_ctrl_bench.sv
module rstseq_clk_ctrl_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W1    = 5;
    localparam int W2    = 9;
    localparam int E_RST = 2;
    localparam int E_CLK = E_RST + W1 + 1;
    localparam int E_END = E_CLK + W2 + 1;
    localparam int WIN   = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic a_en = 0, a_dis = 0, a_busy, a_done, a_gate, a_rst;
    logic b_en = 0, b_dis = 0, b_busy, b_done, b_gate, b_rst;

    // Instance with reset line, active-low stop bit, cold state: clock on, held in reset.
    rstseq_clk_ctrl #(
        .WAIT1_CYC (W1), .WAIT2_CYC (W2), .HAS_RESET (1'b1),
        .CLK_ACTIVE_LOW (1'b1), .CLK_INIT (1'b1), .RST_INIT (1'b1)
    ) u_rstseq_clk_ctrl (
        .clk (clk), .rst (rst), .en_req (a_en), .dis_req (a_dis),
        .busy (a_busy), .done (a_done), .gate_bit (a_gate), .per_rst (a_rst)
    );

    // Instance without reset line, active-high enable bit, clock off.
    rstseq_clk_ctrl #(
        .WAIT1_CYC (W1), .WAIT2_CYC (W2), .HAS_RESET (1'b0),
        .CLK_ACTIVE_LOW (1'b0), .CLK_INIT (1'b0), .RST_INIT (1'b0)
    ) u_rstseq_clk_ctrl_nr (
        .clk (clk), .rst (rst), .en_req (b_en), .dis_req (b_dis),
        .busy (b_busy), .done (b_done), .gate_bit (b_gate), .per_rst (b_rst)
    );

    int  sel = 0;
    logic o_busy, o_done, o_clk, o_rst;
    always_comb begin
        if (sel == 0) begin
            o_busy = a_busy; o_done = a_done; o_clk = ~a_gate; o_rst = a_rst;
        end else begin
            o_busy = b_busy; o_done = b_done; o_clk = b_gate;  o_rst = b_rst;
        end
    end

    int n_chk = 0, n_fail = 0;
    int r_rst_up, r_rst_dn, r_clk_up, r_clk_dn, r_done, r_done_cnt;
    int r_busy_dn, r_busy_rise, r_busy_cyc, r_rst_hi;
    logic timeout = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input int kind, input bit val);
        if (sel == 0) begin
            a_en  = val && (kind == 1 || kind == 3);
            a_dis = val && (kind == 2 || kind == 3);
        end else begin
            b_en  = val && (kind == 1 || kind == 3);
            b_dis = val && (kind == 2 || kind == 3);
        end
    endtask

    // start: 1 enable, 2 disable, 3 both. inj_at: cycle offset for a stray pulse.
    task automatic observe(input int s, input int start, input int inj_at, input int inj_kind);
        logic p_busy, p_clk, p_rst;
        sel = s;
        @(negedge clk);
        p_busy = o_busy; p_clk = o_clk; p_rst = o_rst;
        r_rst_up = -1; r_rst_dn = -1; r_clk_up = -1; r_clk_dn = -1; r_done = -1;
        r_done_cnt = 0; r_busy_dn = -1; r_busy_rise = 0; r_busy_cyc = 0; r_rst_hi = 0;
        drive(start, 1'b1);
        @(negedge clk);
        drive(start, 1'b0);
        for (int n = 0; n < WIN; n++) begin
            drive(inj_kind, 1'b0);
            if (o_rst && !p_rst && r_rst_up < 0) r_rst_up = n;
            if (!o_rst && p_rst && r_rst_dn < 0) r_rst_dn = n;
            if (o_clk && !p_clk && r_clk_up < 0) r_clk_up = n;
            if (!o_clk && p_clk && r_clk_dn < 0) r_clk_dn = n;
            if (o_done) begin
                r_done_cnt++;
                if (r_done < 0) r_done = n;
            end
            if (!o_busy && p_busy && r_busy_dn < 0) r_busy_dn = n;
            if (o_busy && !p_busy && n > 0) r_busy_rise++;
            if (o_busy) r_busy_cyc++;
            if (o_rst) r_rst_hi++;
            p_busy = o_busy; p_clk = o_clk; p_rst = o_rst;
            if (n == inj_at) drive(inj_kind, 1'b1);
            @(negedge clk);
        end
    endtask

    task automatic main_seq();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "A busy", a_busy, 0);
        chk("R1", "A done", a_done, 0);
        chk("R1", "A gate_bit", a_gate, 0);
        chk("R1", "A per_rst", a_rst, 1);
        chk("R1", "B gate_bit", b_gate, 0);
        chk("R1", "B per_rst", b_rst, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "A busy after release", a_busy, 0);
        chk("R1", "A per_rst after release", a_rst, 1);

        // R3: clock on but held in reset -> full sequence
        observe(0, 1, -1, 0);
        chk("R3", "reset fall", r_rst_dn, E_END);
        chk("R3", "done edge", r_done, E_END);
        chk("R3", "done count", r_done_cnt, 1);
        chk("R3", "clock never dropped", r_clk_dn, -1);
        chk("R11", "A gate_bit when running", a_gate, 0);

        // R2: already running
        observe(0, 1, -1, 0);
        chk("R2", "done edge", r_done, 1);
        chk("R2", "busy cycles", r_busy_cyc, 1);
        chk("R2", "busy fall", r_busy_dn, 1);
        chk("R2", "reset untouched", r_rst_hi, 0);
        chk("R2", "clock untouched", r_clk_dn, -1);

        // R8: disable in idle
        observe(0, 2, -1, 0);
        chk("R8", "clock off edge", r_clk_dn, 0);
        chk("R8", "reset untouched", r_rst_up, -1);
        chk("R8", "no busy", r_busy_cyc, 0);
        chk("R8", "no done", r_done_cnt, 0);
        chk("R11", "A gate_bit when stopped", a_gate, 1);

        // R4/R5/R6: full timing from a stopped, released peripheral
        observe(0, 1, -1, 0);
        chk("R4", "reset rise", r_rst_up, E_RST);
        chk("R5", "clock rise", r_clk_up, E_CLK);
        chk("R6", "reset fall", r_rst_dn, E_END);
        chk("R6", "done edge", r_done, E_END);
        chk("R6", "done count", r_done_cnt, 1);
        chk("R6", "busy fall", r_busy_dn, E_END);

        // R9: stray requests at every offset inside the sequence
        for (int k = 0; k < E_END; k++) begin
            for (int kind = 1; kind <= 3; kind++) begin
                observe(0, 2, -1, 0);
                observe(0, 1, k, kind);
                chk("R9", "reset rise", r_rst_up, E_RST);
                chk("R9", "clock rise", r_clk_up, E_CLK);
                chk("R9", "reset fall", r_rst_dn, E_END);
                chk("R9", "done count", r_done_cnt, 1);
                chk("R9", "no second sequence", r_busy_rise, 0);
                chk("R9", "clock kept", r_clk_dn, -1);
            end
        end

        // R10: both requests at once in idle (peripheral running)
        observe(0, 3, -1, 0);
        chk("R10", "clock off edge", r_clk_dn, 0);
        chk("R10", "no busy", r_busy_cyc, 0);
        chk("R10", "no done", r_done_cnt, 0);
        chk("R10", "reset untouched", r_rst_up, -1);

        // R7: no reset line
        observe(1, 1, -1, 0);
        chk("R7", "clock rise", r_clk_up, 2);
        chk("R7", "done edge", r_done, 2);
        chk("R7", "busy fall", r_busy_dn, 2);
        chk("R7", "reset never high", r_rst_hi, 0);
        chk("R11", "B gate_bit when running", b_gate, 1);
        observe(1, 1, -1, 0);
        chk("R2", "B already running done", r_done, 1);
        chk("R2", "B busy cycles", r_busy_cyc, 1);
        observe(1, 2, -1, 0);
        chk("R8", "B clock off edge", r_clk_dn, 0);
        chk("R8", "B no done", r_done_cnt, 0);
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (100000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule